// File: doc/BRIEF.md
# Mixed-Page-Size Associative Address Translator

This block translates a 32-bit effective address into a 32-bit real address. Each lookup also carries an 8-bit address-space identifier. It holds 64 page descriptors, and software manages all of them. Any descriptor can sit in any slot. Every slot is compared against a lookup at the same time. Each descriptor carries its own 3-bit page-size code, so one array can hold small and large pages side by side, and pages from several address spaces can share it.

Software fills slots through an indexed write port and can inspect any slot through an indexed read port. A lookup is presented on the search port, and one clock later the block reports:
- whether a slot matched;
- which slot won, and whether more than one slot matched;
- the translated address;
- the winning slot's attribute bits, passed through unchanged.

A single-cycle flush input clears every slot's valid flag. The block has no replacement policy, raises no exceptions and does not enforce attributes.

Top module: `tlb_xlate`

## Requirements
- R1: After synchronous reset every slot is invalid, and every search result output is 0 until the first search completes.
- R2: A write stores the page number, size code, valid flag, space tag, frame number and attribute bits at `wr_idx`. A read request returns those stored values on the `rd_*` outputs one clock later.
- R3: Size code k (0..7) selects a page of 1 KB·4^k, so the offset is 10+2k bits wide. On a hit, real-address bits 31 down to 10+2k come from frame-number bits 21 down to 2k, and bits below 10+2k are copied from the effective address.
- R4: A slot compares only effective-address bits 31 down to 10+2k against its page number. A difference in a lower bit still hits, and a difference at bit 10+2k misses.
- R5: A slot whose stored space tag is 0 matches any `srch_pid`. Any other tag must equal `srch_pid` exactly.
- R6: A slot whose valid flag is 0 never matches.
- R7: When several slots match, the lowest-numbered slot supplies the index, address and attributes, and `srch_multi` is 1 together with `srch_hit`.
- R8: The result of a search appears one clock after `srch_en`, with `srch_done` high for that one cycle. While no search is requested, the result outputs hold their values.
- R9: A write takes effect only for searches requested on a later cycle. A search requested in the same cycle as the write sees the old contents.
- R10: `inv_all` clears every valid flag in one clock. It overrides a write in the same cycle, whose other fields are still stored.
- R11: On a miss, `srch_hit`, `srch_multi`, `srch_idx`, `srch_ra` and `srch_attr` are all 0.
- R12: On a hit, `srch_attr` equals the attribute bits stored in the winning slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write a slot |
| wr_idx | input | 6 | Slot to write |
| wr_epn | input | 22 | Effective page number (address bits 31:10) |
| wr_size | input | 3 | Page-size code |
| wr_valid | input | 1 | Valid flag to store |
| wr_pid | input | 8 | Space tag to store (0 = any) |
| wr_rpn | input | 22 | Real frame number (address bits 31:10) |
| wr_attr | input | 10 | Attribute bits |
| rd_en | input | 1 | Read a slot |
| rd_idx | input | 6 | Slot to read |
| rd_epn | output | 22 | Stored page number |
| rd_size | output | 3 | Stored size code |
| rd_valid | output | 1 | Stored valid flag |
| rd_pid | output | 8 | Stored space tag |
| rd_rpn | output | 22 | Stored frame number |
| rd_attr | output | 10 | Stored attributes |
| inv_all | input | 1 | Clear all valid flags |
| srch_en | input | 1 | Start a search |
| srch_ea | input | 32 | Effective address to translate |
| srch_pid | input | 8 | Current address-space identifier |
| srch_done | output | 1 | Search result valid this cycle |
| srch_hit | output | 1 | A slot matched |
| srch_multi | output | 1 | More than one slot matched |
| srch_idx | output | 6 | Winning slot |
| srch_ra | output | 32 | Translated real address |
| srch_attr | output | 10 | Winning slot's attributes |

## Verification
The cases hardest to reach from the ports are the ones where the outcome depends on the cycle in which things are requested. One is a search that shares a cycle with a write to the very slot it would hit. The other is a flush that shares a cycle with a write. The bench drives both requests on the same falling edge so that the same rising edge captures them. It then repeats the search one cycle later and reads the slot back, which shows both the old and the new view. The size-boundary cases are covered by loading one page of each of the eight sizes and toggling the address bit just below and just above each size's offset boundary.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int EA_W    = 32;
  localparam int PID_W   = 8;
  localparam int OFF_MIN = 10;
  localparam int EPN_W   = EA_W - OFF_MIN;
  localparam int SIZE_W  = 3;
  localparam int ATTR_W  = 10;

  typedef struct packed {
    logic [EPN_W-1:0]  epn;
    logic [SIZE_W-1:0] size;
    logic [PID_W-1:0]  pid;
  } tag_t;

  typedef struct packed {
    logic [EPN_W-1:0]  rpn;
    logic [ATTR_W-1:0] attr;
  } data_t;

  // Page-number bits that take part in the compare for a size code
  function automatic logic [EPN_W-1:0] epn_mask(input logic [SIZE_W-1:0] s);
    return {EPN_W{1'b1}} << {s, 1'b0};
  endfunction

  // Address bits that pass through from the effective address
  function automatic logic [EA_W-1:0] off_mask(input logic [SIZE_W-1:0] s);
    return ~({EA_W{1'b1}} << (OFF_MIN + 2 * int'(s)));
  endfunction
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tag_t             wr_tag,
  input  logic             wr_valid,
  input  data_t            wr_data,
  input  logic             inv_all,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output tag_t             tag_arr [ENTRIES],
  output data_t            data_arr [ENTRIES],
  output logic [ENTRIES-1:0] vld_arr,
  output tag_t             rd_tag,
  output logic             rd_vld,
  output data_t            rd_data
);
  tag_t  tag_q  [ENTRIES];
  data_t data_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  // Payload storage: written by index, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  // Valid flags: separate so the flush is one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (inv_all) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= wr_valid;
    end
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_tag  <= '0;
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else if (rd_en) begin
      rd_tag  <= tag_q[rd_idx];
      rd_vld  <= vld_q[rd_idx];
      rd_data <= data_q[rd_idx];
    end
  end

  assign tag_arr  = tag_q;
  assign data_arr = data_q;
  assign vld_arr  = vld_q;

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> (vld_q == '0));

  assert_write_sets_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !inv_all) |=> (vld_q[$past(wr_idx)] == $past(wr_valid)));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  tag_t               tag_arr [ENTRIES],
  input  logic [ENTRIES-1:0] vld_arr,
  input  logic [EPN_W-1:0]   ea_pn,
  input  logic [PID_W-1:0]   pid,
  output logic [ENTRIES-1:0] hit_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic pid_ok;
    logic pn_ok;
    assign pid_ok = (tag_arr[g].pid == '0) || (tag_arr[g].pid == pid);
    assign pn_ok  = ((tag_arr[g].epn ^ ea_pn) & epn_mask(tag_arr[g].size)) == '0;
    assign hit_vec[g] = vld_arr[g] && pid_ok && pn_ok;
  end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] hit_vec,
  output logic               any_hit,
  output logic               multi_hit,
  output logic [IDX_W-1:0]   win_idx
);
  always_comb begin
    win_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_idx = IDX_W'(i);
    end
  end

  assign any_hit   = |hit_vec;
  assign multi_hit = (hit_vec & (hit_vec - 1'b1)) != '0;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [EPN_W-1:0]  wr_epn,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic              wr_valid,
  input  logic [PID_W-1:0]  wr_pid,
  input  logic [EPN_W-1:0]  wr_rpn,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [EPN_W-1:0]  rd_epn,
  output logic [SIZE_W-1:0] rd_size,
  output logic              rd_valid,
  output logic [PID_W-1:0]  rd_pid,
  output logic [EPN_W-1:0]  rd_rpn,
  output logic [ATTR_W-1:0] rd_attr,
  input  logic              inv_all,
  input  logic              srch_en,
  input  logic [EA_W-1:0]   srch_ea,
  input  logic [PID_W-1:0]  srch_pid,
  output logic              srch_done,
  output logic              srch_hit,
  output logic              srch_multi,
  output logic [IDX_W-1:0]  srch_idx,
  output logic [EA_W-1:0]   srch_ra,
  output logic [ATTR_W-1:0] srch_attr
);
  tag_t               tag_arr  [ENTRIES];
  data_t              data_arr [ENTRIES];
  logic [ENTRIES-1:0] vld_arr;
  tag_t               rd_tag;
  data_t              rd_data;
  logic [ENTRIES-1:0] hit_vec;
  logic               any_hit;
  logic               multi_hit;
  logic [IDX_W-1:0]   win_idx;

  tlb_entry_array #(.ENTRIES(ENTRIES)) u_array (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag   ('{epn: wr_epn, size: wr_size, pid: wr_pid}),
    .wr_valid (wr_valid),
    .wr_data  ('{rpn: wr_rpn, attr: wr_attr}),
    .inv_all  (inv_all),
    .rd_en    (rd_en),
    .rd_idx   (rd_idx),
    .tag_arr  (tag_arr),
    .data_arr (data_arr),
    .vld_arr  (vld_arr),
    .rd_tag   (rd_tag),
    .rd_vld   (rd_valid),
    .rd_data  (rd_data)
  );

  assign rd_epn  = rd_tag.epn;
  assign rd_size = rd_tag.size;
  assign rd_pid  = rd_tag.pid;
  assign rd_rpn  = rd_data.rpn;
  assign rd_attr = rd_data.attr;

  tlb_match #(.ENTRIES(ENTRIES)) u_match (
    .tag_arr (tag_arr),
    .vld_arr (vld_arr),
    .ea_pn   (srch_ea[EA_W-1:OFF_MIN]),
    .pid     (srch_pid),
    .hit_vec (hit_vec)
  );

  tlb_prio_enc #(.ENTRIES(ENTRIES)) u_prio (
    .hit_vec   (hit_vec),
    .any_hit   (any_hit),
    .multi_hit (multi_hit),
    .win_idx   (win_idx)
  );

  // Merge the winner's frame with the page offset
  logic [SIZE_W-1:0] win_size;
  data_t             win_data;
  logic [EA_W-1:0]   pass_mask;
  logic [EA_W-1:0]   ra_next;

  assign win_size  = tag_arr[win_idx].size;
  assign win_data  = data_arr[win_idx];
  assign pass_mask = off_mask(win_size);
  assign ra_next   = ({win_data.rpn, {OFF_MIN{1'b0}}} & ~pass_mask) | (srch_ea & pass_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      srch_done  <= 1'b0;
      srch_hit   <= 1'b0;
      srch_multi <= 1'b0;
      srch_idx   <= '0;
      srch_ra    <= '0;
      srch_attr  <= '0;
    end else begin
      srch_done <= srch_en;
      if (srch_en) begin
        srch_hit   <= any_hit;
        srch_multi <= multi_hit;
        srch_idx   <= any_hit ? win_idx : '0;
        srch_ra    <= any_hit ? ra_next : '0;
        srch_attr  <= any_hit ? win_data.attr : '0;
      end
    end
  end

  assert_done_after_req_R8: assert property (@(posedge clk) disable iff (rst)
    srch_en |=> srch_done);

  assert_no_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !srch_en |=> (!srch_done && $stable(srch_ra) && $stable(srch_hit)));

  assert_multi_has_hit_R7: assert property (@(posedge clk) disable iff (rst)
    srch_multi |-> srch_hit);

  assert_miss_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (srch_done && !srch_hit) |-> (srch_ra == '0 && srch_idx == '0 && !srch_multi && srch_attr == '0));

  assert_offset_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (srch_done && srch_hit) |-> (srch_ra[OFF_MIN-1:0] == $past(srch_ea[OFF_MIN-1:0])));
endmodule

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [21:0] wr_epn = '0;
  logic [2:0]  wr_size = '0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_pid = '0;
  logic [21:0] wr_rpn = '0;
  logic [9:0]  wr_attr = '0;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_idx = '0;
  logic [21:0] rd_epn;
  logic [2:0]  rd_size;
  logic        rd_valid;
  logic [7:0]  rd_pid;
  logic [21:0] rd_rpn;
  logic [9:0]  rd_attr;
  logic        inv_all = 1'b0;
  logic        srch_en = 1'b0;
  logic [31:0] srch_ea = '0;
  logic [7:0]  srch_pid = '0;
  logic        srch_done;
  logic        srch_hit;
  logic        srch_multi;
  logic [5:0]  srch_idx;
  logic [31:0] srch_ra;
  logic [9:0]  srch_attr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlb_xlate uut (.*);

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    chk(act == exp, req, what, act, exp);
  endtask

  function automatic logic [31:0] exp_ra(input logic [21:0] rpn, input int k,
                                         input logic [31:0] ea);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (i >= 10 + 2 * k) r[i] = rpn[i - 10];
      else r[i] = ea[i];
    end
    return r;
  endfunction

  task automatic put(input int idx, input logic [21:0] epn, input logic [2:0] sz,
                     input logic v, input logic [7:0] pid, input logic [21:0] rpn,
                     input logic [9:0] attr);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_epn = epn; wr_size = sz;
    wr_valid = v; wr_pid = pid; wr_rpn = rpn; wr_attr = attr;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] ea, input logic [7:0] pid);
    srch_en = 1'b1; srch_ea = ea; srch_pid = pid;
    @(negedge clk);
    srch_en = 1'b0;
  endtask

  task automatic peek(input int idx);
    rd_en = 1'b1; rd_idx = 6'(idx);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic flush();
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
  endtask

  task automatic expect_miss(input string req);
    chk_eq(req, "done", srch_done, 1);
    chk_eq(req, "hit", srch_hit, 0);
    chk_eq(req, "multi", srch_multi, 0);
    chk_eq(req, "idx", srch_idx, 0);
    chk_eq(req, "ra", srch_ra, 0);
    chk_eq(req, "attr", srch_attr, 0);
  endtask

  task automatic t_reset();
    chk_eq("R1", "done after reset", srch_done, 0);
    chk_eq("R1", "hit after reset", srch_hit, 0);
    chk_eq("R1", "ra after reset", srch_ra, 0);
    look(32'h0000_0000, 8'h00);
    expect_miss("R1");
    look(32'hFFFF_FFFF, 8'h7E);
    expect_miss("R11");
    peek(5);
    chk_eq("R1", "slot 5 valid", rd_valid, 0);
  endtask

  task automatic t_readback();
    put(9, 22'h2ABCD, 3'd5, 1'b1, 8'h44, 22'h13579, 10'h2C3);
    peek(9);
    chk_eq("R2", "epn", rd_epn, 22'h2ABCD);
    chk_eq("R2", "size", rd_size, 5);
    chk_eq("R2", "valid", rd_valid, 1);
    chk_eq("R2", "pid", rd_pid, 8'h44);
    chk_eq("R2", "rpn", rd_rpn, 22'h13579);
    chk_eq("R2", "attr", rd_attr, 10'h2C3);
  endtask

  task automatic t_sizes();
    for (int k = 0; k < 8; k++) begin
      logic [21:0] epn;
      logic [21:0] rpn;
      logic [31:0] ea;
      logic [31:0] ea2;
      logic [9:0]  at;
      flush();
      epn = {3'(k + 1), 19'h2A5A5};
      rpn = 22'h3C0F0 ^ 22'(k * 22'h01111);
      at  = 10'(10'h101 + k);
      put(k + 3, epn, 3'(k), 1'b1, 8'h00, rpn, at);
      ea = {epn, 10'h1C3};
      look(ea, 8'h11);
      chk_eq("R3", "hit", srch_hit, 1);
      chk_eq("R3", "idx", srch_idx, 6'(k + 3));
      chk_eq("R3", "ra", srch_ra, exp_ra(rpn, k, ea));
      chk_eq("R12", "attr", srch_attr, at);
      if (k > 0) begin
        ea2 = ea ^ (32'h1 << (9 + 2 * k));
        look(ea2, 8'h11);
        chk_eq("R4", "hit below boundary", srch_hit, 1);
        chk_eq("R4", "ra below boundary", srch_ra, exp_ra(rpn, k, ea2));
      end
      ea2 = ea ^ (32'h1 << (10 + 2 * k));
      look(ea2, 8'h11);
      chk_eq("R4", "miss at boundary", srch_hit, 0);
    end
  endtask

  task automatic t_pid();
    flush();
    put(20, 22'h01234, 3'd1, 1'b1, 8'h5A, 22'h00ABC, 10'h011);
    look({22'h01234, 10'h000}, 8'h5A);
    chk_eq("R5", "tag equal hit", srch_hit, 1);
    look({22'h01234, 10'h000}, 8'h5B);
    chk_eq("R5", "tag differ miss", srch_hit, 0);
    put(21, 22'h05678, 3'd0, 1'b1, 8'h00, 22'h00DEF, 10'h022);
    look({22'h05678, 10'h3FF}, 8'h33);
    chk_eq("R5", "tag zero any", srch_hit, 1);
    chk_eq("R5", "tag zero idx", srch_idx, 21);
  endtask

  task automatic t_invalid();
    flush();
    put(30, 22'h0F0F0, 3'd2, 1'b0, 8'h00, 22'h11111, 10'h0AA);
    look({22'h0F0F0, 10'h055}, 8'h01);
    chk_eq("R6", "invalid slot miss", srch_hit, 0);
  endtask

  task automatic t_multi();
    logic [31:0] ea;
    flush();
    put(40, 22'h2F000, 3'd2, 1'b1, 8'h00, 22'h0AAAA, 10'h0F1);
    put(12, 22'h2F000, 3'd4, 1'b1, 8'h00, 22'h15555, 10'h0F2);
    ea = {22'h2F000, 10'h2B7};
    look(ea, 8'h09);
    chk_eq("R7", "hit", srch_hit, 1);
    chk_eq("R7", "multi", srch_multi, 1);
    chk_eq("R7", "lowest idx", srch_idx, 12);
    chk_eq("R7", "ra from lowest", srch_ra, exp_ra(22'h15555, 4, ea));
    chk_eq("R7", "attr from lowest", srch_attr, 10'h0F2);
  endtask

  task automatic t_timing();
    logic [31:0] ra_hold;
    ra_hold = srch_ra;
    chk_eq("R8", "done pulse", srch_done, 1);
    @(negedge clk);
    chk_eq("R8", "done low when idle", srch_done, 0);
    chk_eq("R8", "hit held", srch_hit, 1);
    chk_eq("R8", "ra held", srch_ra, ra_hold);
  endtask

  task automatic t_same_cycle();
    flush();
    wr_en = 1'b1; wr_idx = 6'd50; wr_epn = 22'h3ABCD; wr_size = 3'd0;
    wr_valid = 1'b1; wr_pid = 8'h00; wr_rpn = 22'h01010; wr_attr = 10'h333;
    srch_en = 1'b1; srch_ea = {22'h3ABCD, 10'h001}; srch_pid = 8'h00;
    @(negedge clk);
    wr_en = 1'b0; srch_en = 1'b0;
    expect_miss("R9");
    look({22'h3ABCD, 10'h001}, 8'h00);
    chk_eq("R9", "next cycle hit", srch_hit, 1);
    chk_eq("R9", "next cycle idx", srch_idx, 50);
  endtask

  task automatic t_flush();
    put(3, 22'h12345, 3'd0, 1'b1, 8'h00, 22'h00001, 10'h001);
    put(7, 22'h23456, 3'd0, 1'b1, 8'h00, 22'h00002, 10'h002);
    inv_all = 1'b1;
    wr_en = 1'b1; wr_idx = 6'd3; wr_epn = 22'h34567; wr_size = 3'd0;
    wr_valid = 1'b1; wr_pid = 8'h00; wr_rpn = 22'h00003; wr_attr = 10'h003;
    @(negedge clk);
    inv_all = 1'b0; wr_en = 1'b0;
    look({22'h23456, 10'h000}, 8'h00);
    chk_eq("R10", "old slot gone", srch_hit, 0);
    look({22'h34567, 10'h000}, 8'h00);
    chk_eq("R10", "written slot invalid", srch_hit, 0);
    peek(3);
    chk_eq("R10", "slot 3 valid", rd_valid, 0);
    chk_eq("R10", "slot 3 epn stored", rd_epn, 22'h34567);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_readback();
    t_sizes();
    t_pid();
    t_invalid();
    t_multi();
    t_timing();
    t_same_cycle();
    t_flush();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule